// File: doc/BRIEF.md
# Byte-Wide Converter Result Bus Port

This block takes a 14-bit converter result (12 magnitude bits, a polarity flag and an overrange flag) and presents it to an 8-bit processor bus as two bytes. Each byte lane is modelled as an 8-bit data vector plus an output-enable, which stands in for a three-state driver. A result is captured into an internal latch on a one-cycle valid pulse from the converter.

The three control pins (chip select, high-byte enable, low-byte enable) can work in two directions. In direct mode the host drives them, and they gate the two byte lanes with no clock involved. In handshake mode the block drives them itself. It then walks through a fixed sequence: first the high byte with its flag and a one-clock load strobe, then the low byte in the same way, and then it releases the bus. Handshake output begins when a new result is latched while the mode input is held high, or at once when the mode input rises. A result that arrives during a transfer waits in a pending register and is sent after the transfer ends. An active-low test input forces every data bit of both lanes high.

Top module: `resout_bus_port`

## Requirements
- R1: The low lane carries result bits [7:0]. The high lane carries {2'b00, overrange, polarity, result bits [11:8]}, with result bits [11:8] in lane bits [3:0], polarity in bit 4 and overrange in bit 5.
- R2: When the block is idle and the registered mode is low, the low lane is enabled exactly when cs_n and lbe_n are both low. This is combinational from the pins.
- R3: When the block is idle and the registered mode is low, the high lane is enabled exactly when cs_n and hbe_n are both low.
- R4: In direct mode, cs_n high disables both lanes whatever the byte enables are.
- R5: ctl_oe (control pins driven by the block) changes only on the clock edge that samples mode_i. It is high while the sampled mode is high or a transfer is running, and low otherwise.
- R6: With mode_i held high, a newly latched result starts a transfer on the same edge that latches it, and the transfer carries that result.
- R7: A transfer lasts four cycles, in order: hflag_n low with the high lane on; hflag_n low with ld_n low; lflag_n low with the low lane on; lflag_n low with ld_n low. After that the lanes are off and all control outputs are high.
- R8: A rising mode_i starts a transfer of the current latched result on the next edge, even if mode_i then drops at once.
- R9: A result that arrives during a transfer does not change the transfer in progress. It is sent in a new transfer one idle cycle after the current one ends.
- R10: test_n low forces both lanes' data to 8'hFF and leaves the enables unchanged.
- R11: During reset both lanes are off, ctl_oe is low and ld_n, hflag_n and lflag_n are high.
- R12: With the sampled mode high and no transfer running, the pin inputs do not enable either lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| res_valid | input | 1 | One-cycle pulse: new conversion result |
| res_data | input | 12 | Result magnitude bits |
| res_pol | input | 1 | Result polarity, high for positive |
| res_ovr | input | 1 | Result overrange |
| mode_i | input | 1 | Low: direct mode; high or pulsed high: handshake |
| test_n | input | 1 | Low forces all lane data bits high |
| cs_n | input | 1 | Direct-mode master enable, active low |
| hbe_n | input | 1 | Direct-mode high lane enable, active low |
| lbe_n | input | 1 | Direct-mode low lane enable, active low |
| ctl_oe | output | 1 | Block drives the control pins |
| ld_n_o | output | 1 | Handshake load strobe, active low |
| hflag_n_o | output | 1 | Handshake high-byte flag, active low |
| lflag_n_o | output | 1 | Handshake low-byte flag, active low |
| lo_d | output | 8 | Low lane data |
| lo_oe | output | 1 | Low lane drive enable |
| hi_d | output | 8 | High lane data |
| hi_oe | output | 1 | High lane drive enable |

## Verification
The assertions check on every cycle the properties of the strobe and flag outputs: the flags never overlap, the load strobe lasts one cycle and always sits under a flag, the low flag only follows the high-byte strobe, and lane data is held steady while a flag is low. They also check that chip-select gating, the test force and the one-edge direction change hold on every cycle. Only the bench scenarios can show which result a transfer carries, the wait of a pending result behind a running transfer, entry on a short mode pulse, and the exact byte layout of random results.

// File: rtl/resout_pkg.sv
package resout_pkg;
   typedef enum logic [2:0] {
      HS_IDLE  = 3'd0,
      HS_HI    = 3'd1,
      HS_HI_LD = 3'd2,
      HS_LO    = 3'd3,
      HS_LO_LD = 3'd4
   } hs_state_t;
endpackage

// File: rtl/resout_latch.sv
module resout_latch #(
   parameter int WORD_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              busy,
   output logic [WORD_W-1:0] lat_word,
   output logic              load
);
   logic [WORD_W-1:0] pend_word;
   logic              pend_v;
   logic              take_new;
   logic              take_pend;

   always_comb begin
      take_new  = in_valid & ~busy;
      take_pend = pend_v & ~busy & ~in_valid;
      load      = take_new | take_pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_word  <= '0;
         pend_word <= '0;
         pend_v    <= 1'b0;
      end else begin
         if (take_new)
            lat_word <= in_word;
         else if (take_pend)
            lat_word <= pend_word;
         if (in_valid && busy) begin
            pend_word <= in_word;
            pend_v    <= 1'b1;
         end else if (load) begin
            pend_v    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/resout_hs_fsm.sv
module resout_hs_fsm
   import resout_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   output hs_state_t state,
   output logic      busy
);
   hs_state_t nxt;

   always_comb begin
      unique case (state)
         HS_IDLE:  nxt = start ? HS_HI : HS_IDLE;
         HS_HI:    nxt = HS_HI_LD;
         HS_HI_LD: nxt = HS_LO;
         HS_LO:    nxt = HS_LO_LD;
         HS_LO_LD: nxt = HS_IDLE;
         default:  nxt = HS_IDLE;
      endcase
      busy = (state != HS_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= HS_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/resout_lane.sv
module resout_lane #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              force_n,
   input  logic              drive,
   output logic [BYTE_W-1:0] d_o,
   output logic              oe_o
);
   always_comb begin
      d_o  = force_n ? byte_i : {BYTE_W{1'b1}};
      oe_o = drive;
   end
endmodule

// File: rtl/resout_bus_port.sv
module resout_bus_port
   import resout_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              res_pol,
   input  logic              res_ovr,
   input  logic              mode_i,
   input  logic              test_n,
   input  logic              cs_n,
   input  logic              hbe_n,
   input  logic              lbe_n,
   output logic              ctl_oe,
   output logic              ld_n_o,
   output logic              hflag_n_o,
   output logic              lflag_n_o,
   output logic [BYTE_W-1:0] lo_d,
   output logic              lo_oe,
   output logic [BYTE_W-1:0] hi_d,
   output logic              hi_oe
);
   localparam int HI_W   = DATA_W - BYTE_W;
   localparam int WORD_W = DATA_W + 2;
   localparam int PAD_W  = BYTE_W - HI_W - 2;

   generate
      if (DATA_W <= BYTE_W || HI_W + 2 > BYTE_W) begin : g_bad_width
         $error("resout_bus_port: result does not fit two lanes");
      end
   endgenerate

   logic              mode_q;
   logic              load;
   logic              start;
   logic              busy;
   logic              direct;
   hs_state_t         state;
   logic [WORD_W-1:0] lat_word;
   logic [DATA_W-1:0] lat_data;
   logic              lat_pol;
   logic              lat_ovr;
   logic [1:0][BYTE_W-1:0] lane_byte;
   logic [1:0][BYTE_W-1:0] lane_d;
   logic [1:0]        lane_drv;
   logic [1:0]        lane_oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= mode_i;
   end

   resout_latch #(.WORD_W(WORD_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (res_valid),
      .in_word  ({res_ovr, res_pol, res_data}),
      .busy     (busy),
      .lat_word (lat_word),
      .load     (load)
   );

   assign start = (mode_i & ~mode_q) | (load & mode_q);

   resout_hs_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .state (state),
      .busy  (busy)
   );

   always_comb begin
      lat_data = lat_word[DATA_W-1:0];
      lat_pol  = lat_word[DATA_W];
      lat_ovr  = lat_word[DATA_W+1];
      direct   = ~mode_q & ~busy;

      lane_byte[0] = lat_data[BYTE_W-1:0];
      lane_byte[1] = {{PAD_W{1'b0}}, lat_ovr, lat_pol, lat_data[DATA_W-1:BYTE_W]};

      lane_drv[0] = busy ? (state == HS_LO || state == HS_LO_LD)
                         : (direct & ~cs_n & ~lbe_n);
      lane_drv[1] = busy ? (state == HS_HI || state == HS_HI_LD)
                         : (direct & ~cs_n & ~hbe_n);

      ctl_oe    = mode_q | busy;
      hflag_n_o = ~(state == HS_HI || state == HS_HI_LD);
      lflag_n_o = ~(state == HS_LO || state == HS_LO_LD);
      ld_n_o    = ~(state == HS_HI_LD || state == HS_LO_LD);
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         resout_lane #(.BYTE_W(BYTE_W)) u_lane (
            .byte_i  (lane_byte[g]),
            .force_n (test_n),
            .drive   (lane_drv[g]),
            .d_o     (lane_d[g]),
            .oe_o    (lane_oe[g])
         );
      end
   endgenerate

   assign lo_d  = lane_d[0];
   assign lo_oe = lane_oe[0];
   assign hi_d  = lane_d[1];
   assign hi_oe = lane_oe[1];
endmodule

// File: rtl/resout_bus_port_chk.sv
module resout_bus_port_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_i,
   input logic              test_n,
   input logic              cs_n,
   input logic              ctl_oe,
   input logic              ld_n_o,
   input logic              hflag_n_o,
   input logic              lflag_n_o,
   input logic [BYTE_W-1:0] lo_d,
   input logic              lo_oe,
   input logic [BYTE_W-1:0] hi_d,
   input logic              hi_oe
);
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!hflag_n_o && !lflag_n_o));                                       // R7
   AST_LD_UNDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n_o |-> (!hflag_n_o || !lflag_n_o));                           // R7
   AST_LD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n_o |=> ld_n_o);                                                // R7
   AST_HI_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lflag_n_o) |-> $past(!ld_n_o && !hflag_n_o));                 // R7
   AST_CS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_oe && cs_n) |-> (!lo_oe && !hi_oe));                          // R4
   AST_TEST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      !test_n |-> (lo_d == {BYTE_W{1'b1}} && hi_d == {BYTE_W{1'b1}}));    // R10
   AST_DIR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mode_i) && !ctl_oe) |=> ctl_oe);                             // R5
   AST_HI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!hflag_n_o && $past(!hflag_n_o) && $stable(test_n)) |-> $stable(hi_d)); // R9
endmodule

bind resout_bus_port resout_bus_port_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .test_n    (test_n),
   .cs_n      (cs_n),
   .ctl_oe    (ctl_oe),
   .ld_n_o    (ld_n_o),
   .hflag_n_o (hflag_n_o),
   .lflag_n_o (lflag_n_o),
   .lo_d      (lo_d),
   .lo_oe     (lo_oe),
   .hi_d      (hi_d),
   .hi_oe     (hi_oe)
);

// File: tb/resout_bus_port_tb.sv
`timescale 1ns/1ps
module resout_bus_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [11:0] res_data = '0;
   logic        res_pol = 1'b0;
   logic        res_ovr = 1'b0;
   logic        mode_i = 1'b0;
   logic        test_n = 1'b1;
   logic        cs_n = 1'b1;
   logic        hbe_n = 1'b1;
   logic        lbe_n = 1'b1;
   logic        ctl_oe, ld_n_o, hflag_n_o, lflag_n_o, lo_oe, hi_oe;
   logic [7:0]  lo_d, hi_d;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   resout_bus_port u_dut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
      .res_pol(res_pol), .res_ovr(res_ovr), .mode_i(mode_i), .test_n(test_n),
      .cs_n(cs_n), .hbe_n(hbe_n), .lbe_n(lbe_n), .ctl_oe(ctl_oe),
      .ld_n_o(ld_n_o), .hflag_n_o(hflag_n_o), .lflag_n_o(lflag_n_o),
      .lo_d(lo_d), .lo_oe(lo_oe), .hi_d(hi_d), .hi_oe(hi_oe)
   );

   function automatic logic [7:0] exp_lo(logic [11:0] d, logic t);
      return t ? d[7:0] : 8'hFF;
   endfunction

   function automatic logic [7:0] exp_hi(logic [11:0] d, logic p, logic o, logic t);
      return t ? {2'b00, o, p, d[11:8]} : 8'hFF;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic load_result(logic [11:0] d, logic p, logic o);
      res_data = d; res_pol = p; res_ovr = o; res_valid = 1'b1;
      tick();
      res_valid = 1'b0;
   endtask

   task automatic check_hs(logic [11:0] d, logic p, logic o, string tag);
      chk({tag, " hi flag"}, {ctl_oe, hflag_n_o, lflag_n_o, ld_n_o, hi_oe, lo_oe}, 6'b101110);
      chk({tag, " hi data"}, hi_d, exp_hi(d, p, o, test_n));
      tick();
      chk({tag, " hi strobe"}, {hflag_n_o, lflag_n_o, ld_n_o, hi_oe, lo_oe}, 5'b01010);
      chk({tag, " hi data held"}, hi_d, exp_hi(d, p, o, test_n));
      tick();
      chk({tag, " lo flag"}, {hflag_n_o, lflag_n_o, ld_n_o, hi_oe, lo_oe}, 5'b10101);
      chk({tag, " lo data"}, lo_d, exp_lo(d, test_n));
      tick();
      chk({tag, " lo strobe"}, {hflag_n_o, lflag_n_o, ld_n_o, hi_oe, lo_oe}, 5'b10001);
      tick();
      chk({tag, " R7 release"}, {hflag_n_o, lflag_n_o, ld_n_o, hi_oe, lo_oe}, 5'b11100);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] d;
      logic p, o;
      void'($urandom(32'h5EED));
      tick();
      chk("R11 reset outputs", {ctl_oe, ld_n_o, hflag_n_o, lflag_n_o, lo_oe, hi_oe}, 6'b011100);
      tick();
      rst_n = 1'b1;
      tick();

      // directed direct-mode reads
      load_result(12'hA5C, 1'b1, 1'b0);
      cs_n = 0; lbe_n = 0; hbe_n = 1; #1;
      chk("R2 low lane on", {lo_oe, hi_oe}, 2'b10);
      chk("R1 low byte", lo_d, 8'h5C);
      hbe_n = 0; #1;
      chk("R3 high lane on", {lo_oe, hi_oe}, 2'b11);
      chk("R1 high byte", hi_d, 8'h1A);
      cs_n = 1; #1;
      chk("R4 cs high", {lo_oe, hi_oe}, 2'b00);
      cs_n = 0; test_n = 0; #1;
      chk("R10 forced", {lo_d, hi_d, lo_oe, hi_oe}, {16'hFFFF, 2'b11});
      test_n = 1; cs_n = 1; hbe_n = 1; lbe_n = 1;

      // random direct-mode traffic
      for (int i = 0; i < 300; i++) begin
         d = 12'($urandom); p = 1'($urandom); o = 1'($urandom);
         load_result(d, p, o);
         cs_n = 1'($urandom); hbe_n = 1'($urandom); lbe_n = 1'($urandom);
         test_n = ($urandom % 4) != 0;
         #1;
         chk("R2 low enable", lo_oe, !cs_n && !lbe_n);
         chk("R3 R4 high enable", hi_oe, !cs_n && !hbe_n);
         chk("R1 R10 low data", lo_d, exp_lo(d, test_n));
         chk("R1 R10 high data", hi_d, exp_hi(d, p, o, test_n));
         chk("R5 direct ctl", ctl_oe, 1'b0);
         tick();
      end
      cs_n = 1; hbe_n = 1; lbe_n = 1; test_n = 1;

      // mode goes high: direction changes only on the next edge
      load_result(12'h3C7, 1'b0, 1'b1);
      mode_i = 1'b1; #1;
      chk("R5 before edge", ctl_oe, 1'b0);
      tick();
      chk("R5 after edge", ctl_oe, 1'b1);
      check_hs(12'h3C7, 1'b0, 1'b1, "R8 rise");
      chk("R5 held ctl", ctl_oe, 1'b1);

      // held high: pins are ignored while idle
      cs_n = 0; hbe_n = 0; lbe_n = 0; #1;
      chk("R12 pins ignored", {lo_oe, hi_oe}, 2'b00);
      cs_n = 1; hbe_n = 1; lbe_n = 1;

      load_result(12'h9E1, 1'b1, 1'b1);
      check_hs(12'h9E1, 1'b1, 1'b1, "R6 completion");

      // new result during a transfer waits
      load_result(12'h46B, 1'b1, 1'b0);
      chk("R9 first hi", hi_d, exp_hi(12'h46B, 1'b1, 1'b0, 1'b1));
      load_result(12'hB28, 1'b0, 1'b1);
      chk("R9 hi kept", hi_d, exp_hi(12'h46B, 1'b1, 1'b0, 1'b1));
      chk("R9 strobe", ld_n_o, 1'b0);
      tick();
      chk("R9 lo kept", lo_d, exp_lo(12'h46B, 1'b1));
      tick();
      tick();
      chk("R9 idle gap", {hflag_n_o, lflag_n_o, ld_n_o}, 3'b111);
      tick();
      check_hs(12'hB28, 1'b0, 1'b1, "R9 pending");

      // mode low again
      mode_i = 1'b0;
      tick();
      chk("R5 mode low", ctl_oe, 1'b0);

      // one-cycle mode pulse from direct mode
      load_result(12'h7F0, 1'b0, 1'b0);
      chk("R8 no start", ctl_oe, 1'b0);
      mode_i = 1'b1;
      tick();
      mode_i = 1'b0;
      check_hs(12'h7F0, 1'b0, 1'b0, "R8 pulse");
      chk("R5 after pulse", ctl_oe, 1'b0);
      cs_n = 0; lbe_n = 0; #1;
      chk("R2 direct resumes", lo_oe, 1'b1);
      cs_n = 1; lbe_n = 1;

      // test force during a transfer
      test_n = 0;
      mode_i = 1'b1;
      tick();
      mode_i = 1'b0;
      check_hs(12'h7F0, 1'b0, 1'b0, "R10 transfer");
      test_n = 1;

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule